// File: doc/BRIEF.md
# Presettable decade up/down counter

This block is one decimal digit of a counter. It holds a value from 0 to 9 and steps it by one whenever one of its two count inputs shows a rising edge. A rising edge on the up input increments the digit and a rising edge on the down input decrements it, so there is no direction pin. A parallel load, active low, copies a 4-bit preset into the digit. A master clear, active high, forces the digit to zero. Presetting a start value shortens the count cycle, which lets the digit act as a programmable divide-by-n.

Both count inputs may come from anywhere, so each one passes through a two-flop synchronizer and a rising-edge detector on the single system clock. The inputs idle high, and a count is taken on the return from low to high. Two active-low terminal outputs let digits be chained. The carry output is low while the digit sits at 9 and the up input is low, and it rises together with the up edge that wraps the digit to 0. The borrow output does the same for 0 and the down input. A chain of instances therefore forms a multi-digit counter when each carry drives the next up input and each borrow drives the next down input.

Top module: `dudc_counter`

## Requirements
- R1: While `rst` is high, or at any clock edge where `clear_i` is high, the count becomes 0. Clear takes priority over load and over counting. After `rst`, both terminal outputs are high.
- R2: At a clock edge where `clear_i` is low and `load_n_i` is low, the count takes the value of `preset_i`. This overrides any count edge in the same cycle. While `load_n_i` stays low, count edges have no effect.
- R3: A synchronized rising edge on `cnt_up_i` increments the count by one, and 9 wraps to 0.
- R4: A synchronized rising edge on `cnt_dn_i` decrements the count by one, and 0 wraps to 9.
- R5: The count changes only on a rising edge, a load or a clear. Falling edges and steady levels leave it unchanged. Rising edges on both count inputs in the same cycle also leave it unchanged.
- R6: From a loaded invalid code (10 to 15), an up step gives 0 and a down step gives 9.
- R7: `carry_n_o` is low exactly while the count is 9 and the synchronized up level is low. It is high in every other case.
- R8: `borrow_n_o` is low exactly while the count is 0 and the synchronized down level is low. It is high in every other case.
- R9: A level change on a count input reaches the synchronized level at the second clock edge after the change. A resulting rising edge updates the count at the third clock edge. Load and clear update the count at the first clock edge.
- R10: When the carry of one instance drives the up input of a second, and the borrow drives its down input, the pair counts as a two-digit decimal counter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_up_i | input | 1 | Count-up input, idles high, counts on a rising edge, asynchronous |
| cnt_dn_i | input | 1 | Count-down input, idles high, counts on a rising edge, asynchronous |
| load_n_i | input | 1 | Parallel load, active low, synchronous to clk |
| clear_i | input | 1 | Master clear, active high, synchronous to clk |
| preset_i | input | 4 | Preset value for the parallel load |
| count_o | output | 4 | Current BCD count |
| carry_n_o | output | 1 | Overflow terminal output, active low |
| borrow_n_o | output | 1 | Underflow terminal output, active low |

## Verification
Two pairs of functions can land in the same clock cycle. A detected count edge can meet a load or a clear. A rising edge on the up input can meet one on the down input. The bench provokes the first pair by raising a count input and then asserting load, or clear, two clock edges later, so that the edge detector fires on the same edge that samples the control. It then expects the preset value, or zero, with no step applied. For the second pair it raises both inputs on the same clock phase and expects the count to hold. It also times the carry and borrow edges against the step that wraps the digit.

// File: rtl/dudc_pkg.sv
package dudc_pkg;

  // Kind of step the digit takes in one system clock cycle
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;

endpackage

// File: rtl/dudc_edge_sync.sv
module dudc_edge_sync #(
  parameter int   LINES    = 2,
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] lvl_next_o,
  output logic [LINES-1:0] rise_o
);

  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    // chain[0..STAGES-1] synchronizer, chain[STAGES] previous level
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= {DEPTH{IDLE_LVL}};
      else     chain <= {chain[DEPTH-2:0], raw_i[g]};
    end

    assign lvl_next_o[g] = chain[STAGES-2];
    assign lvl_o[g]      = chain[STAGES-1];
    assign rise_o[g]     = chain[STAGES-1] & ~chain[STAGES];

    // R5
    rise_single_chk: assert property (@(posedge clk) disable iff (rst)
      rise_o[g] |=> !rise_o[g])
      else $error("rise pulse longer than one cycle");
  end

endmodule

// File: rtl/dudc_digit_core.sv
module dudc_digit_core
  import dudc_pkg::*;
#(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         load_n_i,
  input  logic [W-1:0] preset_i,
  input  logic         up_rise_i,
  input  logic         dn_rise_i,
  output logic [W-1:0] count_d_o,
  output logic [W-1:0] count_q_o
);

  localparam logic [W-1:0] TOP  = W'(MAXV);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  step_e        step;
  logic [W-1:0] inc_val;
  logic [W-1:0] dec_val;

  always_comb begin
    if (up_rise_i && !dn_rise_i)      step = STEP_UP;
    else if (dn_rise_i && !up_rise_i) step = STEP_DN;
    else                              step = STEP_HOLD;
  end

  // Wrap at the top and pull invalid codes back into range
  always_comb begin
    if (count_q_o >= TOP) inc_val = ZERO;
    else                  inc_val = count_q_o + ONE;
    if (count_q_o == ZERO || count_q_o > TOP) dec_val = TOP;
    else                                      dec_val = count_q_o - ONE;
  end

  always_comb begin
    if (clear_i)        count_d_o = ZERO;
    else if (!load_n_i) count_d_o = preset_i;
    else begin
      case (step)
        STEP_UP: count_d_o = inc_val;
        STEP_DN: count_d_o = dec_val;
        default: count_d_o = count_q_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q_o <= ZERO;
    else     count_q_o <= count_d_o;
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> count_q_o == ZERO)
    else $error("clear did not zero the count");

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !load_n_i) |=> count_q_o == $past(preset_i))
    else $error("load did not copy preset");

  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && up_rise_i && !dn_rise_i && count_q_o == TOP)
    |=> count_q_o == ZERO)
    else $error("up step from top did not wrap");

  // R4
  dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && dn_rise_i && !up_rise_i && count_q_o == ZERO)
    |=> count_q_o == TOP)
    else $error("down step from zero did not wrap");

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && (up_rise_i == dn_rise_i)) |=> $stable(count_q_o))
    else $error("count moved without a single edge, load or clear");

  // R6
  invalid_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i && up_rise_i && !dn_rise_i && count_q_o > TOP)
    |=> count_q_o == ZERO)
    else $error("invalid code did not recover on up step");

endmodule

// File: rtl/dudc_term.sv
module dudc_term #(
  parameter int W    = 4,
  parameter int MAXV = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] count_d_i,
  input  logic [W-1:0] count_q_i,
  input  logic         up_lvl_next_i,
  input  logic         dn_lvl_next_i,
  input  logic         up_lvl_i,
  input  logic         dn_lvl_i,
  output logic         carry_n_o,
  output logic         borrow_n_o
);

  localparam logic [W-1:0] TOP = W'(MAXV);

  // Registered from next-cycle values so outputs line up with the count
  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n_o  <= 1'b1;
      borrow_n_o <= 1'b1;
    end else begin
      carry_n_o  <= !((count_d_i == TOP) && !up_lvl_next_i);
      borrow_n_o <= !((count_d_i == '0)  && !dn_lvl_next_i);
    end
  end

  // R7
  carry_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    carry_n_o == !((count_q_i == TOP) && !up_lvl_i))
    else $error("carry output inconsistent with count and up level");

  // R8
  borrow_lvl_chk: assert property (@(posedge clk) disable iff (rst)
    borrow_n_o == !((count_q_i == '0) && !dn_lvl_i))
    else $error("borrow output inconsistent with count and down level");

endmodule

// File: rtl/dudc_counter.sv
module dudc_counter #(
  parameter int W           = 4,
  parameter int MAXV        = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_up_i,
  input  logic         cnt_dn_i,
  input  logic         load_n_i,
  input  logic         clear_i,
  input  logic [W-1:0] preset_i,
  output logic [W-1:0] count_o,
  output logic         carry_n_o,
  output logic         borrow_n_o
);

  localparam int LN_UP = 0;
  localparam int LN_DN = 1;
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_next;
  logic [LINES-1:0] rise;
  logic [W-1:0]     count_d;
  logic [W-1:0]     count_q;

  assign raw[LN_UP] = cnt_up_i;
  assign raw[LN_DN] = cnt_dn_i;

  dudc_edge_sync #(
    .LINES    (LINES),
    .STAGES   (SYNC_STAGES),
    .IDLE_LVL (1'b1)
  ) u_sync (
    .clk        (clk),
    .rst        (rst),
    .raw_i      (raw),
    .lvl_o      (lvl),
    .lvl_next_o (lvl_next),
    .rise_o     (rise)
  );

  dudc_digit_core #(
    .W    (W),
    .MAXV (MAXV)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_i),
    .load_n_i  (load_n_i),
    .preset_i  (preset_i),
    .up_rise_i (rise[LN_UP]),
    .dn_rise_i (rise[LN_DN]),
    .count_d_o (count_d),
    .count_q_o (count_q)
  );

  dudc_term #(
    .W    (W),
    .MAXV (MAXV)
  ) u_term (
    .clk           (clk),
    .rst           (rst),
    .count_d_i     (count_d),
    .count_q_i     (count_q),
    .up_lvl_next_i (lvl_next[LN_UP]),
    .dn_lvl_next_i (lvl_next[LN_DN]),
    .up_lvl_i      (lvl[LN_UP]),
    .dn_lvl_i      (lvl[LN_DN]),
    .carry_n_o     (carry_n_o),
    .borrow_n_o    (borrow_n_o)
  );

  assign count_o = count_q;

endmodule

// File: tb/dudc_counter_tb.sv
module dudc_counter_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       up = 1'b1, dn = 1'b1, load_n = 1'b1, clr = 1'b0;
  logic [3:0] pre = 4'd0;
  logic [3:0] cnt;
  logic       carry_n, borrow_n;

  // cascade pair
  logic       up_a = 1'b1, dn_a = 1'b1, clr_a = 1'b0;
  logic [3:0] cnt_a, cnt_b;
  logic       cy_a, bw_a, cy_b, bw_b;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  dudc_counter dut_i (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .load_n_i(load_n),
    .clear_i(clr), .preset_i(pre), .count_o(cnt), .carry_n_o(carry_n),
    .borrow_n_o(borrow_n));

  dudc_counter casc_lo (
    .clk(clk), .rst(rst), .cnt_up_i(up_a), .cnt_dn_i(dn_a), .load_n_i(1'b1),
    .clear_i(clr_a), .preset_i(4'd0), .count_o(cnt_a), .carry_n_o(cy_a),
    .borrow_n_o(bw_a));

  dudc_counter casc_hi (
    .clk(clk), .rst(rst), .cnt_up_i(cy_a), .cnt_dn_i(bw_a), .load_n_i(1'b1),
    .clear_i(clr_a), .preset_i(4'd0), .count_o(cnt_b), .carry_n_o(cy_b),
    .borrow_n_o(bw_b));

  localparam logic [1:0] OP_LD = 2'd0, OP_UP = 2'd1, OP_DN = 2'd2, OP_CL = 2'd3;
  // {op, data, expected count}
  localparam logic [9:0] VEC [0:15] = '{
    {OP_LD, 4'd7,  4'd7}, {OP_UP, 4'd0, 4'd8}, {OP_UP, 4'd0, 4'd9},
    {OP_UP, 4'd0,  4'd0}, {OP_DN, 4'd0, 4'd9}, {OP_DN, 4'd0, 4'd8},
    {OP_LD, 4'd0,  4'd0}, {OP_DN, 4'd0, 4'd9}, {OP_LD, 4'd12, 4'd12},
    {OP_UP, 4'd0,  4'd0}, {OP_LD, 4'd14, 4'd14}, {OP_DN, 4'd0, 4'd9},
    {OP_UP, 4'd0,  4'd0}, {OP_UP, 4'd0, 4'd1}, {OP_CL, 4'd0, 4'd0},
    {OP_LD, 4'd5,  4'd5}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    up = 1'b0; nedge(4); up = 1'b1; nedge(4);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; nedge(4); dn = 1'b1; nedge(4);
  endtask

  task automatic do_load(input logic [3:0] v);
    pre = v; load_n = 1'b0; nedge(1); load_n = 1'b1; nedge(1);
  endtask

  task automatic casc_up();
    up_a = 1'b0; nedge(4); up_a = 1'b1; nedge(8);
  endtask

  task automatic casc_dn();
    dn_a = 1'b0; nedge(4); dn_a = 1'b1; nedge(8);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    nedge(4);
    rst = 1'b0;
    nedge(1);
    chk("R1 reset count", cnt, 4'd0);
    chk("R1 reset carry", {3'b0, carry_n}, 4'd1);
    chk("R1 reset borrow", {3'b0, borrow_n}, 4'd1);

    // Table walk
    for (int i = 0; i < 16; i++) begin
      case (VEC[i][9:8])
        OP_LD: begin do_load(VEC[i][7:4]); chk("R2 table load", cnt, VEC[i][3:0]); end
        OP_UP: begin pulse_up(); chk("R3/R6 table up", cnt, VEC[i][3:0]); end
        OP_DN: begin pulse_dn(); chk("R4/R6 table down", cnt, VEC[i][3:0]); end
        default: begin clr = 1'b1; nedge(1); clr = 1'b0; nedge(1);
                 chk("R1 table clear", cnt, VEC[i][3:0]); end
      endcase
    end

    // R9 / R7: carry timing around a wrap
    do_load(4'd9);
    chk("R7 carry high with up idle high", {3'b0, carry_n}, 4'd1);
    up = 1'b0; nedge(1);
    chk("R9 carry not yet low after one edge", {3'b0, carry_n}, 4'd1);
    nedge(1);
    chk("R7 carry low at 9 with up low", {3'b0, carry_n}, 4'd0);
    nedge(2);
    up = 1'b1; nedge(2);
    chk("R7 carry rises with up edge", {3'b0, carry_n}, 4'd1);
    chk("R9 count not yet stepped", cnt, 4'd9);
    nedge(1);
    chk("R9 count wraps at third edge", cnt, 4'd0);
    nedge(2);

    // R8: borrow timing
    dn = 1'b0; nedge(3);
    chk("R8 borrow low at 0 with down low", {3'b0, borrow_n}, 4'd0);
    dn = 1'b1; nedge(2);
    chk("R8 borrow rises with down edge", {3'b0, borrow_n}, 4'd1);
    nedge(2);
    chk("R4 wrap to 9", cnt, 4'd9);
    chk("R8 borrow high away from 0", {3'b0, borrow_n}, 4'd1);

    // R5: falling edge alone does nothing
    up = 1'b0; nedge(5);
    chk("R5 falling edge ignored", cnt, 4'd9);
    dn = 1'b0; nedge(5);
    // both rise together
    up = 1'b1; dn = 1'b1; nedge(5);
    chk("R5 simultaneous edges hold", cnt, 4'd9);

    // R2: load meets an up edge in the same cycle
    do_load(4'd3);
    up = 1'b0; nedge(4);
    up = 1'b1; nedge(2);
    pre = 4'd6; load_n = 1'b0; nedge(1); load_n = 1'b1; nedge(3);
    chk("R2 load wins over same-cycle edge", cnt, 4'd6);

    // R2: held load blocks counting
    pre = 4'd2; load_n = 1'b0;
    pulse_up();
    chk("R2 held load blocks count", cnt, 4'd2);
    load_n = 1'b1; nedge(1);

    // R1: clear meets down edge and active load
    dn = 1'b0; nedge(4);
    dn = 1'b1; nedge(2);
    clr = 1'b1; load_n = 1'b0; pre = 4'd8; nedge(1);
    clr = 1'b0; load_n = 1'b1; nedge(3);
    chk("R1 clear wins over load and edge", cnt, 4'd0);

    // R10: cascade
    for (int k = 0; k < 12; k++) casc_up();
    chk("R10 cascade low digit after 12 up", cnt_a, 4'd2);
    chk("R10 cascade high digit after 12 up", cnt_b, 4'd1);
    for (int k = 0; k < 3; k++) casc_dn();
    chk("R10 cascade low digit after 3 down", cnt_a, 4'd9);
    chk("R10 cascade high digit after 3 down", cnt_b, 4'd0);
    casc_dn();
    chk("R10 cascade low digit 8", cnt_a, 4'd8);
    clr_a = 1'b1; nedge(1); clr_a = 1'b0; nedge(1);
    casc_dn();
    chk("R10 cascade underflow low digit", cnt_a, 4'd9);
    chk("R10 cascade underflow high digit", cnt_b, 4'd9);

    finish_run();
  end

endmodule